// File: doc/BRIEF.md
# Phase-Lock Loss Detector with Hold-Off Stretch

This block watches the two phase-error pulses coming out of a phase/frequency comparator and decides whether the synthesizer loop is in lock. It runs on the reference-oscillator clock and measures how many oscillator cycles an error pulse stays active. When a pulse of either direction lasts longer than a selectable limit of 4 or 8 oscillator cycles, the loop is treated as unlocked.

Once the unlock flag is set, it stays set for a selectable number of comparison periods: 4, 8, 16 or 32. The comparison period is marked by a one-cycle tick from the reference divider. Any further over-limit pulse restarts this hold-off interval, so the flag clears only after a complete quiet interval.

The result drives an open-drain style lock-detect pin. The pin is pulled low while the loop is unlocked and released while it is locked. The threshold and stretch settings are picked up at comparison ticks. A polarity control inverts the active level of both error inputs.

Top module: `lkdet_top`

## Requirements
- R1: After reset the block reports unlocked: `lock_det_oe` = 1 and `lock_det_o` = 0.
- R2: With the threshold selection at 0, an error pulse of 4 consecutive active cycles does not set unlock. A pulse of 5 or more cycles sets unlock, visible on the outputs right after the clock edge that ends the 5th active cycle.
- R3: With the threshold selection at 1, a pulse of 8 active cycles does not set unlock and a pulse of 9 cycles does.
- R4: `up_err` and `dn_err` are treated alike. An error is active while either input is at its active level, so a run made of an `up_err` stretch directly followed by a `dn_err` stretch counts as one pulse.
- R5: With `pol_inv` = 0 the error inputs are active high. With `pol_inv` = 1 they are active low. The setting applies immediately.
- R6: After the last over-limit pulse, unlock clears on the comparison tick that brings the tick count to 4, 8, 16 or 32, for `ext_sel` = 0, 1, 2 or 3 respectively.
- R7: A new over-limit pulse while unlocked restarts the hold-off count from zero.
- R8: The pulse-width count returns to zero in any cycle with no active error. It saturates instead of wrapping, so an arbitrarily long pulse keeps the block unlocked.
- R9: `thr_sel` and `ext_sel` are sampled only in cycles with `cmp_tick` = 1, and they govern detection from the following cycle on.
- R10: While locked, `lock_det_oe` = 0 and `lock_det_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_tick | input | 1 | One-cycle pulse per comparison period |
| up_err | input | 1 | Phase-error pulse, pump-up direction |
| dn_err | input | 1 | Phase-error pulse, pump-down direction |
| pol_inv | input | 1 | 1: error inputs active low |
| thr_sel | input | 1 | Pulse-width limit: 0 selects 4 cycles, 1 selects 8 cycles |
| ext_sel | input | 2 | Hold-off length: 4 << ext_sel comparison periods |
| lock_det_o | output | 1 | Pin level: 0 while unlocked, 1 (released) while locked |
| lock_det_oe | output | 1 | Pull-down enable, 1 while unlocked |

## Verification
The over-limit decision is combinational on the registered width count. The unlock flag is registered, so it shows on the outputs one edge after the first over-limit cycle. A release shows one edge after the comparison tick that completes the hold-off count. A threshold or stretch change written alongside a tick first acts in the cycle after that tick.

The bench drives inputs on the falling edge and steps its own cycle model at each rising edge. It compares the outputs 1 ns after that edge, so every comparison sees exactly the edges the stimulus has passed through. The directed cases count ticks up to the release and the pulse lengths around each threshold, with the expected values fixed in advance.

// File: rtl/lkdet_pkg.sv
package lkdet_pkg;
  // Base hold-off length is 2**HOLD_BASE_LOG2 comparison periods
  localparam int unsigned HOLD_BASE_LOG2 = 2;

  // Number of comparison ticks the unlock flag is held for a given selection
  function automatic int unsigned hold_len(input logic [1:0] sel);
    return 32'd1 << (HOLD_BASE_LOG2 + int'(sel));
  endfunction
endpackage

// File: rtl/lkdet_cfg_reg.sv
module lkdet_cfg_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       thr_in,
  input  logic [1:0] ext_in,
  output logic       thr_q,
  output logic [1:0] ext_q
);
  logic       thr_d;
  logic [1:0] ext_d;

  always_comb begin
    thr_d = thr_q;
    ext_d = ext_q;
    if (tick) begin
      thr_d = thr_in;
      ext_d = ext_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= 1'b0;
      ext_q <= 2'b00;
    end else begin
      thr_q <= thr_d;
      ext_q <= ext_d;
    end
  end
endmodule

// File: rtl/lkdet_width_meter.sv
module lkdet_width_meter #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned THR_LO = 4,
  parameter int unsigned THR_HI = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err,
  input  logic             thr_sel,
  output logic [CNT_W-1:0] cnt_q,
  output logic             viol
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM_LO  = CNT_W'(THR_LO);
  localparam logic [CNT_W-1:0] LIM_HI  = CNT_W'(THR_HI);

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;

  // cnt_q holds the number of earlier active cycles of the current pulse
  always_comb begin
    limit = thr_sel ? LIM_HI : LIM_LO;
    viol  = err && (cnt_q >= limit);
    if (!err)                 cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lkdet_hold_timer.sv
module lkdet_hold_timer #(
  parameter int unsigned HOLD_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       viol,
  input  logic [1:0] ext_q,
  output logic       unl_q
);
  import lkdet_pkg::*;

  logic [HOLD_W-1:0] h_q, h_d, h_inc, h_len;
  logic              unl_d;

  always_comb begin
    h_inc = h_q + 1'b1;
    h_len = HOLD_W'(hold_len(ext_q));
    unl_d = unl_q;
    h_d   = h_q;
    if (viol) begin
      unl_d = 1'b1;
      h_d   = '0;
    end else if (tick && unl_q) begin
      if (h_inc == h_len) begin
        unl_d = 1'b0;
        h_d   = '0;
      end else begin
        h_d   = h_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q <= 1'b1;
      h_q   <= '0;
    end else begin
      unl_q <= unl_d;
      h_q   <= h_d;
    end
  end
endmodule

// File: rtl/lkdet_top.sv
module lkdet_top #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned THR_LO = 4,
  parameter int unsigned THR_HI = 8,
  parameter int unsigned HOLD_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_tick,
  input  logic       up_err,
  input  logic       dn_err,
  input  logic       pol_inv,
  input  logic       thr_sel,
  input  logic [1:0] ext_sel,
  output logic       lock_det_o,
  output logic       lock_det_oe
);
  logic [1:0]       rst_pipe;
  logic             rst_s;
  logic             err_w;
  logic             viol_w;
  logic [CNT_W-1:0] cnt_w;
  logic             thr_q_w;
  logic [1:0]       ext_q_w;
  logic             unl_w;

  // Reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  assign err_w = (up_err ^ pol_inv) | (dn_err ^ pol_inv);

  lkdet_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_s),
    .tick   (cmp_tick),
    .thr_in (thr_sel),
    .ext_in (ext_sel),
    .thr_q  (thr_q_w),
    .ext_q  (ext_q_w)
  );

  lkdet_width_meter #(.CNT_W(CNT_W), .THR_LO(THR_LO), .THR_HI(THR_HI)) u_meter (
    .clk     (clk),
    .rst_n   (rst_s),
    .err     (err_w),
    .thr_sel (thr_q_w),
    .cnt_q   (cnt_w),
    .viol    (viol_w)
  );

  lkdet_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_s),
    .tick  (cmp_tick),
    .viol  (viol_w),
    .ext_q (ext_q_w),
    .unl_q (unl_w)
  );

  assign lock_det_oe = unl_w;
  assign lock_det_o  = ~unl_w;
endmodule

// File: rtl/lkdet_chk.sv
module lkdet_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_tick,
  input logic             err,
  input logic             viol,
  input logic [CNT_W-1:0] cnt,
  input logic             thr_q,
  input logic [1:0]       ext_q,
  input logic             lock_det_oe
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2
  viol_sets_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> lock_det_oe);

  // R6
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_det_oe) |-> $past(cmp_tick));

  // R8
  idle_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err |=> (cnt == '0));

  // R8
  count_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_tick |=> ($stable(thr_q) && $stable(ext_q)));
endmodule

bind lkdet_top lkdet_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_s),
  .cmp_tick    (cmp_tick),
  .err         (err_w),
  .viol        (viol_w),
  .cnt         (cnt_w),
  .thr_q       (thr_q_w),
  .ext_q       (ext_q_w),
  .lock_det_oe (lock_det_oe)
);

// File: tb/sim_lkdet_top.sv
`timescale 1ns/1ps
module sim_lkdet_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmp_tick, up_err, dn_err, pol_inv, thr_sel;
  logic [1:0] ext_sel;
  logic       lock_det_o, lock_det_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // configuration applied by the stimulus tasks
  logic       pol = 1'b0;
  logic       thr = 1'b0;
  logic [1:0] ext = 2'b00;

  // cycle model state
  int   m_cnt, m_h;
  logic m_thr, m_unl;
  logic [1:0] m_ext;

  always #2.5 clk = ~clk;

  lkdet_top u0 (
    .clk(clk), .rst_n(rst_n), .cmp_tick(cmp_tick), .up_err(up_err),
    .dn_err(dn_err), .pol_inv(pol_inv), .thr_sel(thr_sel), .ext_sel(ext_sel),
    .lock_det_o(lock_det_o), .lock_det_oe(lock_det_oe)
  );

  function automatic int lim_of(input logic t);
    return t ? 8 : 4;
  endfunction

  function automatic int len_of(input logic [1:0] e);
    return 4 << e;
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic u, input logic d, input logic t);
    logic e, v;
    e = (u ^ pol) | (d ^ pol);
    v = e && (m_cnt >= lim_of(m_thr));
    if (v) begin
      m_unl = 1'b1; m_h = 0;
    end else if (t && m_unl) begin
      if (m_h + 1 == len_of(m_ext)) begin m_unl = 1'b0; m_h = 0; end
      else m_h = m_h + 1;
    end
    m_cnt = !e ? 0 : (m_cnt == 15 ? 15 : m_cnt + 1);
    if (t) begin m_thr = thr; m_ext = ext; end
  endtask

  task automatic cyc(input logic u, input logic d, input logic t, input string tag);
    @(negedge clk);
    up_err = u; dn_err = d; cmp_tick = t;
    pol_inv = pol; thr_sel = thr; ext_sel = ext;
    @(posedge clk); #1;
    model_step(u, d, t);
    check({30'd0, lock_det_oe, lock_det_o}, {30'd0, m_unl, ~m_unl}, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(pol, pol, 1'b0, tag);
  endtask

  task automatic pulse(input int n, input bit use_up, input string tag);
    for (int i = 0; i < n; i++)
      cyc(use_up ? ~pol : pol, use_up ? pol : ~pol, 1'b0, tag);
    idle(1, tag);
  endtask

  // idle with a tick every 4th cycle until locked
  task automatic settle(input string tag);
    for (int i = 0; i < 800; i++) begin
      cyc(pol, pol, (i % 4) == 3, tag);
      if ((i % 4) == 3 && lock_det_oe == 1'b0) break;
    end
  endtask

  // ticks every other cycle, counting until release
  task automatic count_ticks(output int n, input string tag);
    n = 0;
    for (int i = 0; i < 80; i++) begin
      cyc(pol, pol, 1'b1, tag);
      n++;
      if (lock_det_oe == 1'b0) break;
      cyc(pol, pol, 1'b0, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20417));
    rst_n = 1'b0; cmp_tick = 0; up_err = 0; dn_err = 0;
    pol_inv = 0; thr_sel = 0; ext_sel = 0;
    m_cnt = 0; m_h = 0; m_thr = 0; m_ext = 0; m_unl = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(lock_det_oe, 1, "R1 oe");
    check(lock_det_o, 0, "R1 o");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(lock_det_oe, 1, "R1 oe after release");

    settle("R10");
    // R10: locked output levels
    check(lock_det_oe, 0, "R10 oe");
    check(lock_det_o, 1, "R10 o");

    // R2: limit 4
    pulse(4, 1, "R2");
    check(lock_det_oe, 0, "R2 4-cycle pulse");
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, "R2");
    check(lock_det_oe, 1, "R2 5-cycle pulse");
    idle(1, "R2");
    settle("R2");

    // R4: down direction and mixed run
    pulse(5, 0, "R4");
    check(lock_det_oe, 1, "R4 dn pulse");
    settle("R4");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, "R4");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, "R4");
    check(lock_det_oe, 1, "R4 up then dn");
    idle(1, "R4");
    settle("R4");

    // R3: limit 8
    thr = 1'b1;
    settle("R3");
    pulse(8, 1, "R3");
    check(lock_det_oe, 0, "R3 8-cycle pulse");
    pulse(9, 0, "R3");
    check(lock_det_oe, 1, "R3 9-cycle pulse");
    settle("R3");

    // R9: new limit not used before a tick
    thr = 1'b0;
    pulse(5, 1, "R9");
    check(lock_det_oe, 0, "R9 before tick");
    cyc(0, 0, 1, "R9");
    pulse(5, 1, "R9");
    check(lock_det_oe, 1, "R9 after tick");
    settle("R9");

    // R5: active-low inputs
    pol = 1'b1;
    idle(2, "R5");
    check(lock_det_oe, 0, "R5 idle high");
    pulse(5, 1, "R5");
    check(lock_det_oe, 1, "R5 low pulse");
    settle("R5");
    pol = 1'b0;
    idle(2, "R5");

    // R6: hold-off lengths
    for (int e = 0; e < 4; e++) begin
      ext = e[1:0];
      settle("R6");
      pulse(5, 1, "R6");
      count_ticks(n, "R6");
      check(n, 4 << e, "R6 ticks to release");
    end
    ext = 2'b00;
    settle("R6");

    // R7: restart on new violation
    pulse(5, 1, "R7");
    for (int i = 0; i < 3; i++) begin cyc(0, 0, 1, "R7"); cyc(0, 0, 0, "R7"); end
    check(lock_det_oe, 1, "R7 still unlocked");
    pulse(5, 0, "R7");
    count_ticks(n, "R7");
    check(n, 4, "R7 ticks after restart");

    // R8: gap resets width, long pulse saturates
    settle("R8");
    pulse(4, 1, "R8");
    pulse(4, 1, "R8");
    check(lock_det_oe, 0, "R8 split pulses");
    for (int i = 0; i < 60; i++) cyc(1, 0, (i % 4) == 3, "R8");
    check(lock_det_oe, 1, "R8 long pulse");
    idle(1, "R8");
    count_ticks(n, "R8");
    check(n, 4, "R8 release after long pulse");

    // random phase against the cycle model
    for (int i = 0; i < 4000; i++) begin
      logic u, d, t;
      if ($urandom_range(0, 199) == 0) thr = $urandom_range(0, 1);
      if ($urandom_range(0, 199) == 0) ext = $urandom_range(0, 3);
      if ($urandom_range(0, 299) == 0) pol = ~pol;
      t = ($urandom_range(0, 5) == 0);
      u = ($urandom_range(0, 3) != 0) ? pol : ~pol;
      d = ($urandom_range(0, 5) != 0) ? pol : ~pol;
      if ($urandom_range(0, 399) == 0) begin
        for (int k = 0; k < 10; k++) cyc(~pol, pol, 1'b0, "R6 random");
      end
      cyc(u, d, t, "R6 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule